// File: doc/BRIEF.md
# Reseeding LFSR Test-Pattern Generator

This block is a built-in self-test stimulus source for a combinational circuit under test. It works test-per-clock: on every cycle of a running test it places one complete input vector on the circuit's inputs. There is no scan shifting between vectors. The vectors come from a Fibonacci-style linear feedback shift register. That register is reloaded from a small table of seeds that is fixed when the block is built.

Each table entry pairs a seed with the number of vectors to draw from it. After a start pulse, a controller loads the first usable seed and lets the register run for that entry's count. It then reloads with the next usable entry in table order, with no idle cycle between the two sequences. After the last vector of the last entry it raises done. The entries are meant to be listed in increasing order of their count. An entry with an all-zero seed would lock the register, so the controller passes over it. It also passes over an entry with a zero count.

Top module: `reseed_tpg`

## Requirements
- R1: During and right after reset, `pattern_valid` and `done` are low.
- R2: On the cycle after `start` is sampled high while the block is idle or done, `pattern_valid` rises. `pattern` then equals, unchanged, the seed of the lowest-numbered usable entry, and `seed_index` equals that entry's number.
- R3: Within one sequence the register steps once per cycle. Bit 0 of `pattern` is stage 1 and bit W-1 is stage W. Each stage k+1 takes the old stage k. Stage 1 takes the XOR of the old stages selected by `TAP_MASK` (default stages 2 and 5, mask 5'b10010). So seed 5'b11101 (stages 1..5 = 1,0,1,1,1) is followed by 5'b11011, 5'b10110, 5'b01100, 5'b11000, 5'b10001, 5'b00011, 5'b00111 and 5'b01111.
- R4: Each usable entry produces exactly its length field of valid vectors. A length of 1 produces only the seed.
- R5: Usable entries are applied in ascending table order, and `seed_index` names the entry being applied. The first vector of the next entry directly follows the last vector of the previous one, with no cycle in which `pattern_valid` is low.
- R6: An entry whose seed is all zeros, or whose length is zero, is never loaded and never appears on `seed_index`.
- R7: `done` rises on the cycle after the final vector of the last usable entry. It stays high until a new `start`, and `pattern_valid` is low whenever `done` is high.
- R8: A `start` pulse that arrives while a run is in progress has no effect on the vector stream.
- R9: A `start` pulse while `done` is high begins a fresh run that repeats the same vector stream.
- R10: `pattern` is never all zeros while `pattern_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins a run when the block is idle or done |
| pattern | output | W | Current test vector (bit 0 = stage 1) |
| pattern_valid | output | 1 | High while a vector of the current sequence is driven |
| seed_index | output | IDX_W | Table entry whose sequence is being applied |
| done | output | 1 | High from the cycle after the last vector until the next start |

## Verification
The bench builds the block 5 bits wide with the default taps and a five-entry table. The table holds a one-vector entry, an all-zero seed, the 9-vector sequence starting from seed 5'b11101, a zero-length entry, and a 12-vector entry. With these values one run covers the length-1 case, both kinds of skipped entry, the published step sequence, and back-to-back reloads across entries whose numbers are not adjacent. Two runs are made. The second one receives a stray start in the middle of the run and is restarted from done, so the stream must repeat exactly.

// File: rtl/reseed_tpg_pkg.sv
// Shared types and helpers for the reseeding test-pattern generator.
package reseed_tpg_pkg;

    // Controller phases: waiting for start, emitting vectors, finished.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } run_state_t;

    // Width of an index able to address n entries (at least one bit).
    function automatic int unsigned idx_width(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/seed_table.sv
// Seed table: a constant list of (seed, length) entries fixed by
// parameters. It returns the entry addressed by sel and flags every
// entry as usable or not.
// Assumes: entry k sits at bit k*W of SEEDS and at bit k*LEN_W of LENS.
module seed_table #(
    parameter int unsigned W      = 5,
    parameter int unsigned N      = 4,
    parameter int unsigned LEN_W  = 13,
    parameter int unsigned IDX_W  = 2,
    parameter logic [N*W-1:0]     SEEDS = '1,
    parameter logic [N*LEN_W-1:0] LENS  = '1
) (
    input  logic [IDX_W-1:0] sel,
    output logic [W-1:0]     sel_seed,
    output logic [LEN_W-1:0] sel_len,
    output logic [N-1:0]     usable
);

    logic [W-1:0]     seed_arr [N];
    logic [LEN_W-1:0] len_arr  [N];

    // Unpack each entry and mark it usable when seed and length are nonzero.
    for (genvar k = 0; k < N; k++) begin : g_entry
        assign seed_arr[k] = SEEDS[k*W +: W];
        assign len_arr[k]  = LENS[k*LEN_W +: LEN_W];
        assign usable[k]   = (seed_arr[k] != '0) && (len_arr[k] != '0);
    end

    // Read port: out-of-range selections return an empty entry.
    always_comb begin
        sel_seed = '0;
        sel_len  = '0;
        if (int'(sel) < int'(N)) begin
            sel_seed = seed_arr[sel];
            sel_len  = len_arr[sel];
        end
    end

endmodule

// File: rtl/lfsr_core.sv
// Fibonacci LFSR. Stage 1 is bit 0. On each step every stage moves one
// place toward the higher index, and bit 0 takes the XOR of the stages
// picked by TAP_MASK. A load takes priority over a step.
// Assumes: the seed it is given is nonzero.
module lfsr_core #(
    parameter int unsigned W        = 5,
    parameter logic [W-1:0] TAP_MASK = 5'b10010
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] seed,
    output logic [W-1:0] state
);

    logic fb;

    // Feedback bit from the tapped stages.
    assign fb = ^(state & TAP_MASK);

    // State register: clear on reset, load a seed, or shift one place.
    always_ff @(posedge clk) begin
        if (!rst_n)    state <= '0;
        else if (load) state <= seed;
        else if (step) state <= {state[W-2:0], fb};
    end

endmodule

// File: rtl/reseed_ctrl.sv
// Sequencing controller. It walks the usable table entries in ascending
// order and counts out each entry's vectors. It loads the next entry on
// the same edge that would otherwise step past the last vector, so no
// idle cycle appears between entries. Start is accepted only when idle
// or done.
// Assumes: sel_len is the length of the entry at sel_idx in that cycle.
module reseed_ctrl
    import reseed_tpg_pkg::*;
#(
    parameter int unsigned N     = 4,
    parameter int unsigned LEN_W = 13,
    parameter int unsigned IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [N-1:0]     usable,
    input  logic [LEN_W-1:0] sel_len,
    output logic [IDX_W-1:0] sel_idx,
    output logic             load,
    output logic             step,
    output logic [IDX_W-1:0] cur_idx,
    output logic             valid,
    output logic             done
);

    run_state_t       state_q;
    logic [IDX_W-1:0] idx_q;
    logic [LEN_W-1:0] cnt_q;
    logic             found;
    logic             from_begin;
    logic             last_vec;

    assign from_begin = (state_q != ST_RUN);
    assign last_vec   = (state_q == ST_RUN) && (cnt_q == '0);

    // Find the next usable entry: the first one on a new run, else after idx_q.
    always_comb begin
        found   = 1'b0;
        sel_idx = '0;
        for (int j = 0; j < int'(N); j++) begin
            if (!found && usable[j] && (from_begin || j > int'(idx_q))) begin
                found   = 1'b1;
                sel_idx = IDX_W'(j);
            end
        end
    end

    // Register load and step strobes.
    assign load = found && ((from_begin && start) || last_vec);
    assign step = (state_q == ST_RUN) && (cnt_q != '0);

    // Phase, entry index and remaining-vector counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        if (found) begin
                            state_q <= ST_RUN;
                            idx_q   <= sel_idx;
                            cnt_q   <= sel_len - LEN_W'(1);
                        end else begin
                            state_q <= ST_DONE;
                        end
                    end
                end
                ST_RUN: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - LEN_W'(1);
                    end else if (found) begin
                        idx_q <= sel_idx;
                        cnt_q <= sel_len - LEN_W'(1);
                    end else begin
                        state_q <= ST_DONE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cur_idx = idx_q;
    assign valid   = (state_q == ST_RUN);
    assign done    = (state_q == ST_DONE);

endmodule

// File: rtl/reseed_tpg.sv
// Top level of the reseeding test-pattern generator. It ties the seed
// table, the sequencing controller and the LFSR together. Every output
// comes straight from a register, so vector, valid flag and index change
// together on the clock edge.
// Assumes: the table lists at least one usable entry, and the total of
// the lengths fits a LEN_W-bit count.
module reseed_tpg
    import reseed_tpg_pkg::*;
#(
    parameter int unsigned  W         = 5,
    parameter logic [W-1:0] TAP_MASK  = 5'b10010,
    parameter int unsigned  NUM_SEEDS = 4,
    parameter int unsigned  LEN_W     = 13,
    parameter logic [NUM_SEEDS*W-1:0] SEED_LIST =
        {5'b01001, 5'b10011, 5'b00110, 5'b11101},
    parameter logic [NUM_SEEDS*LEN_W-1:0] LEN_LIST =
        {13'd31, 13'd20, 13'd14, 13'd9},
    localparam int unsigned IDX_W = idx_width(NUM_SEEDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic [W-1:0]     pattern,
    output logic             pattern_valid,
    output logic [IDX_W-1:0] seed_index,
    output logic             done
);

    logic [IDX_W-1:0]     sel_idx;
    logic [W-1:0]         sel_seed;
    logic [LEN_W-1:0]     sel_len;
    logic [NUM_SEEDS-1:0] usable;
    logic                 load;
    logic                 step;

    seed_table #(
        .W(W), .N(NUM_SEEDS), .LEN_W(LEN_W), .IDX_W(IDX_W),
        .SEEDS(SEED_LIST), .LENS(LEN_LIST)
    ) u_table (
        .sel(sel_idx), .sel_seed(sel_seed), .sel_len(sel_len), .usable(usable)
    );

    reseed_ctrl #(
        .N(NUM_SEEDS), .LEN_W(LEN_W), .IDX_W(IDX_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .usable(usable),
        .sel_len(sel_len), .sel_idx(sel_idx), .load(load), .step(step),
        .cur_idx(seed_index), .valid(pattern_valid), .done(done)
    );

    lfsr_core #(
        .W(W), .TAP_MASK(TAP_MASK)
    ) u_lfsr (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .seed(sel_seed), .state(pattern)
    );

endmodule

// File: rtl/reseed_tpg_chk.sv
// Property checker for reseed_tpg. It observes ports only and is bound
// to every instance of the top module.
module reseed_tpg_chk #(
    parameter int unsigned  W        = 5,
    parameter int unsigned  IDX_W    = 2,
    parameter logic [W-1:0] TAP_MASK = 5'b10010
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [W-1:0]     pattern,
    input logic             pattern_valid,
    input logic [IDX_W-1:0] seed_index,
    input logic             done
);

    // R1: outputs are quiet on the cycle after reset.
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!pattern_valid && !done));

    // R3: vectors in the same sequence follow the shift rule.
    p_step_rule_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pattern_valid && $past(pattern_valid) && $stable(seed_index))
        |-> pattern == {$past(pattern[W-2:0]), ^($past(pattern) & TAP_MASK)});

    // R5: the entry index never moves backward within a run.
    p_index_ascends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pattern_valid && $past(pattern_valid)) |-> seed_index >= $past(seed_index));

    // R7: done and valid are never high together.
    p_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !pattern_valid);

    // R7: done holds until a start arrives.
    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R10: no all-zero vector is ever issued.
    p_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pattern_valid |-> pattern != '0);

endmodule

bind reseed_tpg reseed_tpg_chk #(
    .W(W), .IDX_W(IDX_W), .TAP_MASK(TAP_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .pattern(pattern),
    .pattern_valid(pattern_valid), .seed_index(seed_index), .done(done)
);

// File: tb/reseed_tpg_tb.sv
// Scoreboard bench for reseed_tpg. A driver task queues the expected
// vectors, and a monitor pops and compares them at each falling edge.
module reseed_tpg_tb;

    localparam int W = 5;
    localparam int N = 5;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  pattern;
    logic          pattern_valid;
    logic [IW-1:0] seed_index;
    logic          done;

    int total = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 1'b0;
    bit mon_on = 1'b0;
    bit prev_valid = 1'b0;
    bit prev_done = 1'b0;
    bit seen_valid = 1'b0;

    logic [W-1:0] exp_pat[$];
    int           exp_idx[$];

    always #2.5 clk = ~clk;

    reseed_tpg #(
        .W(W), .TAP_MASK(5'b10010), .NUM_SEEDS(N), .LEN_W(13),
        .SEED_LIST({5'b10000, 5'b01010, 5'b11101, 5'b00000, 5'b00001}),
        .LEN_LIST({13'd12, 13'd0, 13'd9, 13'd2, 13'd1})
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .pattern(pattern),
        .pattern_valid(pattern_valid), .seed_index(seed_index), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] nxt(input logic [W-1:0] p);
        return {p[3:0], p[1] ^ p[4]};
    endfunction

    // Driver side: queue the full expected stream of one run.
    task automatic push_run();
        logic [W-1:0] p;
        exp_pat.push_back(5'b00001); exp_idx.push_back(0);      // R4 length 1
        // R3 stated sequence from seed 5'b11101 (entry 2; entry 1 skipped, R6)
        exp_pat.push_back(5'b11101); exp_idx.push_back(2);
        exp_pat.push_back(5'b11011); exp_idx.push_back(2);
        exp_pat.push_back(5'b10110); exp_idx.push_back(2);
        exp_pat.push_back(5'b01100); exp_idx.push_back(2);
        exp_pat.push_back(5'b11000); exp_idx.push_back(2);
        exp_pat.push_back(5'b10001); exp_idx.push_back(2);
        exp_pat.push_back(5'b00011); exp_idx.push_back(2);
        exp_pat.push_back(5'b00111); exp_idx.push_back(2);
        exp_pat.push_back(5'b01111); exp_idx.push_back(2);
        p = 5'b10000;                                            // entry 4 (entry 3 skipped)
        for (int k = 0; k < 12; k++) begin
            exp_pat.push_back(p); exp_idx.push_back(4);
            p = nxt(p);
        end
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Monitor: compare every valid vector and check the run framing.
    always @(negedge clk) begin
        if (mon_on) begin
            if (pattern_valid) begin
                seen_valid = 1'b1;
                check(pattern != '0, "R10", "nonzero vector", int'(pattern), 1);
                if (exp_pat.size() == 0) begin
                    check(1'b0, "R4", "extra vector", int'(pattern), -1);
                end else begin
                    logic [W-1:0] ep;
                    int ei;
                    ep = exp_pat.pop_front();
                    ei = exp_idx.pop_front();
                    check(pattern == ep, "R3", "vector", int'(pattern), int'(ep));
                    check(int'(seed_index) == ei, "R5", "seed_index",
                          int'(seed_index), ei);
                end
            end else if (seen_valid && !done) begin
                check(1'b0, "R5", "gap in valid", 0, 1);
            end
            if (done) check(!pattern_valid, "R7", "valid during done",
                            int'(pattern_valid), 0);
            if (done && !prev_done) begin
                check(prev_valid, "R7", "done one cycle after last vector",
                      int'(prev_valid), 1);
                seen_valid = 1'b0;
            end
            prev_valid = pattern_valid;
            prev_done  = done;
        end
    end

    // Watchdog and summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 3000 && !finished) begin
            finished = 1'b1;
            total++; fails++;
            $display("FAIL R7 watchdog: cycles %0d expected < %0d", cyc, 3000);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!pattern_valid, "R1", "valid in reset", int'(pattern_valid), 0);
        check(!done, "R1", "done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!pattern_valid && !done, "R1", "quiet after reset",
              int'({pattern_valid, done}), 0);
        mon_on = 1'b1;

        // First run: R2 timing on the first vector.
        push_run();
        pulse_start();
        check(pattern_valid && pattern == 5'b00001, "R2", "first vector",
              int'(pattern), 1);
        while (!done) @(negedge clk);
        check(exp_pat.size() == 0, "R4", "vectors left over", exp_pat.size(), 0);

        // R7: done holds with no start.
        repeat (4) @(negedge clk);
        check(done && !pattern_valid, "R7", "done holds", int'(done), 1);

        // Second run from done (R9), with a stray start mid-run (R8).
        push_run();
        pulse_start();
        repeat (5) @(negedge clk);
        pulse_start();
        while (!done) @(negedge clk);
        check(exp_pat.size() == 0, "R8", "stream after stray start",
              exp_pat.size(), 0);
        check(done, "R9", "restart completes", int'(done), 1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule